// File: doc/BRIEF.md
# Two-Level Storage Port Interrupt Combiner

This block gathers interrupt events from a set of storage ports (two by default) and merges them into one host interrupt line. Each port latches incoming event pulses in its own status register. A per-port mask decides which latched events count towards that port's pending flag. The pending flags, together with a software-owned interrupt bit, form a host-level summary. A host mask filters that summary into a single global flag. A global interrupt-off control gates the flag before it drives the registered output.

Software reaches every register over a simple synchronous bus with a valid strobe, a write strobe, a byte address and 16 bits of data. Read data is registered and appears on the clock edge after the request. To acknowledge events, software writes ones back to a status register. Writing back the exact value just read clears the events that were seen, and nothing else. A self-timed soft reset returns the status and mask state to a quiet condition without touching the bus logic.

Top module: `stor_irq_combiner`

## Requirements
- R1: After power-on reset, every port status reads 0x0000, every port mask reads 0x00FF, the host mask reads 0xFFFF, the host summary reads 0x0000, the host control reads 0x0100 (interrupt-off set), and `irq_o` is 0.
- R2: A one on an event input latches the matching port status bit on that clock edge. Port status bits are 0 removed, 1 attached, 2 command done, 3 fatal error, 4 device interrupt and 5 reply queue non-empty. Port p's events are on `port_evt_i[p*6 +: 6]`, and the bit stays set until it is cleared.
- R3: Writing to a port status register (port p at 0x40*p + 0x09) clears each bit 5:0 that is written as one and leaves the rest. Writing bit 7 has no effect, so writing back a value just read clears exactly the events that were seen.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Port status bit 7 is a read-only pending flag, set while any latched bit 5:0 has its port mask bit (port p at 0x40*p + 0x0A, same bit positions) at zero. A mask of 0xFF keeps latching events but never raises pending.
- R6: The host summary (0xBC) shows port p's pending flag in bit p and a software interrupt bit in bit 14. A write to 0xBC sets or clears bit 14 from the written data; the other bits ignore writes.
- R7: Summary bit 15 is a read-only global flag, set while any of summary bits 14:0 is set with its host mask bit (0xBE, same positions, one meaning masked) at zero.
- R8: `irq_o` is registered. It is 1 in the cycle after one in which the global flag is set and host control bit 8 (interrupt-off) is clear, and it is 0 otherwise.
- R9: Host control (0x7C) bits 8 and 15 (page select) store the written value and read back. The other bits read as zero, except bit 13.
- R10: Writing a one to host control bit 13 starts a soft reset. Bit 13 reads one for exactly 3 clocks and then clears itself. While it is one, all port status bits are held at zero (events are dropped), all port masks are forced to 0xFF, the host mask is forced to 0xFFFF, and the software interrupt bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid for this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Register byte address |
| req_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, registered one cycle after a read request |
| port_evt_i | input | 12 | Event pulses, 6 per port, port p in bits p*6+5:p*6 |
| irq_o | output | 1 | Combined host interrupt |

## Verification
The assertions assume that every bus request lasts one cycle and hits at most one register. They also assume that an event input is sampled as a level on each clock edge, so a pulse held for two cycles counts as two events on the same bit. The bench drives every request and every pulse for exactly one cycle, starting at a falling edge, and it uses only the defined register addresses. It makes one deliberate exception: an event and a clearing write aimed at the same bit in the same cycle, to exercise R4. It also sends an event pulse while a soft reset is counting, to show that the event is dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int EVT_W   = 6;
  localparam int PREG_W  = 8;

  localparam logic [ADDR_W-1:0] PORT_STRIDE = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_PSTAT   = 8'h09;
  localparam logic [ADDR_W-1:0] OFS_PMASK   = 8'h0A;
  localparam logic [ADDR_W-1:0] ADR_HCTRL   = 8'h7C;
  localparam logic [ADDR_W-1:0] ADR_HSUM    = 8'hBC;
  localparam logic [ADDR_W-1:0] ADR_HMASK   = 8'hBE;

  localparam int PS_PEND    = 7;
  localparam int HC_IRQ_OFF = 8;
  localparam int HC_SRST    = 13;
  localparam int HC_PAGE    = 15;
  localparam int HS_SOFT    = 14;
  localparam int HS_GLOBAL  = 15;
endpackage

// File: rtl/irqc_port_regs.sv
module irqc_port_regs
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              stat_wr_i,
  input  logic              mask_wr_i,
  input  logic [PREG_W-1:0] wdata_i,
  output logic [PREG_W-1:0] stat_o,
  output logic [PREG_W-1:0] mask_o,
  output logic              pend_o
);
  logic [EVT_W-1:0]  stat_q, stat_d, clr;
  logic [PREG_W-1:0] mask_q, mask_d;

  always_comb begin
    clr    = stat_wr_i ? wdata_i[EVT_W-1:0] : '0;
    // set wins over clear
    stat_d = srst_i ? '0 : ((stat_q & ~clr) | evt_i);
    mask_d = srst_i ? '1 : (mask_wr_i ? wdata_i : mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign pend_o = |(stat_q & ~mask_q[EVT_W-1:0]);
  always_comb begin
    stat_o          = '0;
    stat_o[EVT_W-1:0] = stat_q;
    stat_o[PS_PEND] = pend_o;
  end
  assign mask_o = mask_q;

  // R2 / R4: a pulse is always latched, even against a clear
  p_evt_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R3: bits only drop on a status write or soft reset
  p_clear_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !stat_wr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R5: fully masked port never pends
  p_full_mask_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !stat_o[PS_PEND]);

  // R10: reset cycle leaves quiet state
  p_srst_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (stat_q == '0 && mask_q == '1));
endmodule

// File: rtl/irqc_host_regs.sv
module irqc_host_regs
  import irqc_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int SRST_CYCLES = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_wr_i,
  input  logic                 sum_wr_i,
  input  logic                 hmask_wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_PORTS-1:0] pend_i,
  output logic [DATA_W-1:0]    ctrl_o,
  output logic [DATA_W-1:0]    sum_o,
  output logic [DATA_W-1:0]    hmask_o,
  output logic                 srst_o,
  output logic                 irq_o
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);
  localparam int SRC_W = HS_GLOBAL;

  logic [CNT_W-1:0]  cnt_q;
  logic              irq_off_q, page_q, soft_q, irq_q;
  logic [DATA_W-1:0] hmask_q;
  logic [SRC_W-1:0]  src;
  logic              global_flag, srst_start;

  assign srst_start = ctrl_wr_i && wdata_i[HC_SRST];
  assign srst_o     = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      irq_off_q <= 1'b1;
      page_q    <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        irq_off_q <= wdata_i[HC_IRQ_OFF];
        page_q    <= wdata_i[HC_PAGE];
      end
      if (srst_start)      cnt_q <= CNT_W'(SRST_CYCLES);
      else if (srst_o)     cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hmask_q <= '1;
      soft_q  <= 1'b0;
    end else if (srst_o) begin
      hmask_q <= '1;
      soft_q  <= 1'b0;
    end else begin
      if (hmask_wr_i) hmask_q <= wdata_i;
      if (sum_wr_i)   soft_q  <= wdata_i[HS_SOFT];
    end
  end

  always_comb begin
    src = '0;
    src[NUM_PORTS-1:0] = pend_i;
    src[HS_SOFT]       = soft_q;
  end
  assign global_flag = |(src & ~hmask_q[SRC_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= global_flag && !irq_off_q;
  end

  always_comb begin
    ctrl_o             = '0;
    ctrl_o[HC_IRQ_OFF] = irq_off_q;
    ctrl_o[HC_SRST]    = srst_o;
    ctrl_o[HC_PAGE]    = page_q;
  end
  assign sum_o   = {global_flag, src};
  assign hmask_o = hmask_q;
  assign irq_o   = irq_q;

  // R8: interrupt-off gates the output on the next edge
  p_irq_off_gates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_off_q |=> !irq_o);

  // R7: fully masked host never flags
  p_host_mask_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&hmask_q[SRC_W-1:0]) |-> !sum_o[HS_GLOBAL]);

  // R10: counter only counts down and stays in range
  p_srst_countdown_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_o && !srst_start) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_srst_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SRST_CYCLES));
  p_srst_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_start |=> ctrl_o[HC_SRST]);
endmodule

// File: rtl/stor_irq_combiner.sv
module stor_irq_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int SRST_CYCLES = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic [NUM_PORTS*EVT_W-1:0] port_evt_i,
  output logic                       irq_o
);
  localparam int NSEL = 2*NUM_PORTS + 3;

  logic                 wr_en, srst;
  logic [NUM_PORTS-1:0] stat_sel, mask_sel, pend;
  logic                 ctrl_sel, sum_sel, hmask_sel;
  logic [PREG_W-1:0]    stat_rd [NUM_PORTS];
  logic [PREG_W-1:0]    mask_rd [NUM_PORTS];
  logic [DATA_W-1:0]    ctrl_rd, sum_rd, hmask_rd, rd_mux, rd_q;

  assign wr_en     = req_valid_i && req_write_i;
  assign ctrl_sel  = wr_en && (req_addr_i == ADR_HCTRL);
  assign sum_sel   = wr_en && (req_addr_i == ADR_HSUM);
  assign hmask_sel = wr_en && (req_addr_i == ADR_HMASK);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(p * PORT_STRIDE);
    assign stat_sel[p] = wr_en && (req_addr_i == BASE + OFS_PSTAT);
    assign mask_sel[p] = wr_en && (req_addr_i == BASE + OFS_PMASK);

    irqc_port_regs u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .srst_i    (srst),
      .evt_i     (port_evt_i[p*EVT_W +: EVT_W]),
      .stat_wr_i (stat_sel[p]),
      .mask_wr_i (mask_sel[p]),
      .wdata_i   (req_wdata_i[PREG_W-1:0]),
      .stat_o    (stat_rd[p]),
      .mask_o    (mask_rd[p]),
      .pend_o    (pend[p])
    );
  end

  irqc_host_regs #(
    .NUM_PORTS   (NUM_PORTS),
    .SRST_CYCLES (SRST_CYCLES)
  ) u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_sel),
    .sum_wr_i   (sum_sel),
    .hmask_wr_i (hmask_sel),
    .wdata_i    (req_wdata_i),
    .pend_i     (pend),
    .ctrl_o     (ctrl_rd),
    .sum_o      (sum_rd),
    .hmask_o    (hmask_rd),
    .srst_o     (srst),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (req_addr_i == ADR_HCTRL)  rd_mux = ctrl_rd;
    if (req_addr_i == ADR_HSUM)   rd_mux = sum_rd;
    if (req_addr_i == ADR_HMASK)  rd_mux = hmask_rd;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (req_addr_i == ADDR_W'(p * PORT_STRIDE) + OFS_PSTAT)
        rd_mux = {{(DATA_W-PREG_W){1'b0}}, stat_rd[p]};
      if (req_addr_i == ADDR_W'(p * PORT_STRIDE) + OFS_PMASK)
        rd_mux = {{(DATA_W-PREG_W){1'b0}}, mask_rd[p]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rd_q <= '0;
    else if (req_valid_i && !req_write_i) rd_q <= rd_mux;
  end
  assign rd_data_o = rd_q;

  // R3 / R6 / R9: a write reaches at most one register
  p_one_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_sel, mask_sel, ctrl_sel, sum_sel, hmask_sel}));

  // R6: summary port bits follow the port pending flags
  p_summary_ports_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_rd[NUM_PORTS-1:0] == pend);

  // R10: soft reset holds every port quiet
  p_srst_ports_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (pend == '0));

  initial begin
    if (NSEL < 5) $display("bad port count");
  end
endmodule

// File: tb/stor_irq_combiner_bench.sv
module stor_irq_combiner_bench;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NP*6-1:0] evt = '0;
  logic        irq;
  int          checks = 0, fails = 0;
  logic [15:0] v;

  always #5 clk = ~clk;

  stor_irq_combiner u_stor_irq_combiner (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rd_data_o(rdata),
    .port_evt_i(evt), .irq_o(irq)
  );

  localparam logic [7:0] P0S = 8'h09, P0M = 8'h0A, P1S = 8'h49, P1M = 8'h4A;
  localparam logic [7:0] HC = 8'h7C, HS = 8'hBC, HM = 8'hBE;

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(logic [NP*6-1:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(P0S, v); check("R1 p0 stat", v, 16'h0000);
    rd(P0M, v); check("R1 p0 mask", v, 16'h00FF);
    rd(P1M, v); check("R1 p1 mask", v, 16'h00FF);
    rd(HM, v);  check("R1 hmask", v, 16'hFFFF);
    rd(HS, v);  check("R1 summary", v, 16'h0000);
    rd(HC, v);  check("R1 ctrl", v, 16'h0100);
    check("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_latch;
    wr(P0M, 16'h0000); wr(HM, 16'hFFFC); wr(HC, 16'h0000);
    pulse(12'h004);
    idle(1);
    check("R8 irq on", {15'd0, irq}, 16'd1);
    rd(P0S, v); check("R2 R5 p0 stat", v, 16'h0084);
    rd(HS, v);  check("R6 R7 summary", v, 16'h8001);
  endtask

  task automatic t_w1c;
    pulse(12'h009);
    rd(P0S, v); check("R2 p0 multi", v, 16'h008D);
    wr(P0S, 16'h0004);
    rd(P0S, v); check("R3 partial clear", v, 16'h0089);
    wr(P0S, 16'h0089);
    rd(P0S, v); check("R3 readback ack", v, 16'h0000);
    check("R8 irq off after clear", {15'd0, irq}, 16'd0);
    pulse(12'h03F);
    rd(P0S, v); check("R2 all events", v, 16'h00BF);
    wr(P0S, 16'h00FF);
    rd(P0S, v); check("R3 clear all", v, 16'h0000);
  endtask

  task automatic t_race;
    pulse(12'h010);
    valid = 1'b1; write = 1'b1; addr = P0S; wdata = 16'h0010; evt = 12'h010;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; evt = '0;
    rd(P0S, v); check("R4 set wins", v, 16'h0090);
    valid = 1'b1; write = 1'b1; addr = P0S; wdata = 16'h0010; evt = 12'h002;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; evt = '0;
    rd(P0S, v); check("R4 other bit", v, 16'h0082);
    wr(P0S, 16'h00FF);
  endtask

  task automatic t_portmask;
    wr(P1M, 16'h00FF);
    pulse(12'h800);
    rd(P1S, v); check("R5 masked latch", v, 16'h0020);
    rd(HS, v);  check("R5 masked summary", v, 16'h0000);
    check("R5 irq quiet", {15'd0, irq}, 16'd0);
    wr(P1M, 16'h001F);
    rd(P1S, v); check("R5 unmasked pend", v, 16'h00A0);
    rd(HS, v);  check("R6 port1 summary", v, 16'h8002);
    check("R8 irq port1", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_hostmask;
    wr(HM, 16'hFFFE);
    rd(HS, v); check("R7 host masked", v, 16'h0002);
    check("R7 irq masked", {15'd0, irq}, 16'd0);
    wr(HS, 16'h4003);
    rd(HS, v); check("R6 soft masked", v, 16'h4002);
    wr(HM, 16'hBFFE);
    rd(HS, v); check("R6 R7 soft global", v, 16'hC002);
    check("R7 irq soft", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_ctrl;
    wr(HC, 16'h8100);
    rd(HC, v); check("R9 page readback", v, 16'h8100);
    check("R8 irq gated", {15'd0, irq}, 16'd0);
    wr(HC, 16'h80FF);
    rd(HC, v); check("R9 other bits zero", v, 16'h8000);
    check("R8 irq ungated", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_srst;
    wr(HC, 16'h2000);
    rd(HC, v); check("R10 busy 1", v, 16'h2000);
    rd(HC, v); check("R10 busy 2", v, 16'h2000);
    rd(HC, v); check("R10 busy 3", v, 16'h2000);
    rd(HC, v); check("R10 self clear", v, 16'h0000);
    rd(P1S, v); check("R10 p1 stat", v, 16'h0000);
    rd(P0M, v); check("R10 p0 mask", v, 16'h00FF);
    rd(P1M, v); check("R10 p1 mask", v, 16'h00FF);
    rd(HM, v);  check("R10 hmask", v, 16'hFFFF);
    rd(HS, v);  check("R10 summary", v, 16'h0000);
    check("R10 irq", {15'd0, irq}, 16'd0);
    wr(HC, 16'h2000);
    pulse(12'h001);
    wr(P0M, 16'h0000);
    idle(2);
    rd(P0S, v); check("R10 event dropped", v, 16'h0000);
    rd(P0M, v); check("R10 mask write overridden", v, 16'h00FF);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_latch();
    t_w1c();
    t_race();
    t_portmask();
    t_hostmask();
    t_ctrl();
    t_srst();
    finish_run();
  end
endmodule